// File: doc/BRIEF.md
# Trace Configuration Register Access Gate

This block decides, in the same cycle, whether a hart may touch one of the five configuration registers of its control-transfer trace facility: the machine-level trace control, the supervisor-level trace control, the buffer depth selector, the buffer status word and the guest-supervisor trace control. The CSR access path feeds it the current privilege level, the virtualization flag, the register being addressed, two flags saying whether the machine-level and supervisor-level trace extensions exist, and the trace enable bits taken from the machine-level and hypervisor-level state-enable registers.

The result is a two-bit verdict: the access may go ahead, it raises an illegal-instruction exception, or it raises a virtual-instruction fault. Gating runs in two steps. A routing step applies the privilege, virtualization and extension rules for each register. Accesses that pass routing then go through a state-enable step that may still block them. The block holds no state. Register storage, trap delivery and the trace entries are handled elsewhere.

Top module: `ctr_csr_gate`

## Requirements
- R1: The verdict is 2'b00 (allowed), 2'b01 (illegal instruction) or 2'b10 (virtual-instruction fault). It is never 2'b11.
- R2: The machine control register (selector 3'd0) reaches the state-enable step only at M privilege (priv 2'b11) with the machine extension present. In every other case it is illegal.
- R3: The supervisor control (3'd1), depth (3'd2) and status (3'd3) registers reach the state-enable step in two cases: at M privilege with the machine extension present, or at S privilege (2'b01) without virtualization and with the supervisor extension present.
- R4: At S privilege with virtualization and the supervisor extension present, the status register reaches the state-enable step. In the same conditions the supervisor control and depth registers give a virtual-instruction fault.
- R5: The guest control register (3'd4) reaches the state-enable step at virtualized S privilege with the supervisor extension present. In every other case it follows the supervisor-register rules of R3.
- R6: Any case that R2 to R5 do not cover is illegal. This includes selectors 3'd5 to 3'd7, the reserved privilege code 2'b10, and a missing extension.
- R7: In the state-enable step, M privilege always passes. Below M, a clear machine-level trace enable bit makes the access illegal.
- R8: In the state-enable step, a virtualized access with the machine-level bit set and the hypervisor-level bit clear gives a virtual-instruction fault. When both bits are clear, the result is illegal instruction.
- R9: U privilege (2'b00), virtualized or not, is illegal for every selector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| priv_i | input | 2 | Current privilege: 00 U, 01 S, 10 reserved, 11 M |
| virt_i | input | 1 | Hart is running virtualized |
| sel_i | input | 3 | Register addressed: 0 machine ctl, 1 supervisor ctl, 2 depth, 3 status, 4 guest ctl |
| has_m_ext_i | input | 1 | Machine-level trace extension is present |
| has_s_ext_i | input | 1 | Supervisor-level trace extension is present |
| m_se_ctr_i | input | 1 | Trace enable bit of the machine-level state-enable register |
| h_se_ctr_i | input | 1 | Trace enable bit of the hypervisor-level state-enable register |
| verdict_o | output | 2 | 00 allowed, 01 illegal instruction, 10 virtual-instruction fault |

## Verification
The assertions assume every input is driven to a known 0 or 1. They skip evaluation while any input carries X or Z. They also assume the verdict is read only after the inputs have settled, since the block is pure logic. The stimulus applies each input set shortly after a clock edge and samples at the following falling edge. Every input is held at a defined value from time zero, and the bench sweeps all 1024 input combinations, including the reserved privilege code and the unused selectors.

// File: rtl/ctr_gate_pkg.sv
package ctr_gate_pkg;

    localparam int PRIV_W    = 2;
    localparam int SEL_W     = 3;
    localparam int VERDICT_W = 2;
    localparam int N_REGS    = 5;

    typedef enum logic [PRIV_W-1:0] {
        PRIV_U   = 2'b00,
        PRIV_S   = 2'b01,
        PRIV_RSV = 2'b10,
        PRIV_M   = 2'b11
    } priv_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_M_CTL  = 3'd0,
        SEL_S_CTL  = 3'd1,
        SEL_DEPTH  = 3'd2,
        SEL_STATUS = 3'd3,
        SEL_VS_CTL = 3'd4,
        SEL_RSV5   = 3'd5,
        SEL_RSV6   = 3'd6,
        SEL_RSV7   = 3'd7
    } sel_e;

    typedef enum logic [VERDICT_W-1:0] {
        VERD_OK   = 2'b00,
        VERD_ILL  = 2'b01,
        VERD_VIRT = 2'b10,
        VERD_RSV  = 2'b11
    } verdict_e;

    typedef enum logic [1:0] {
        ROUTE_STATEEN = 2'b00,
        ROUTE_ILL     = 2'b01,
        ROUTE_VIRT    = 2'b10
    } route_e;

    typedef struct packed {
        logic m_ctl;
        logic s_ctl;
        logic s_depth;
        logic s_status;
        logic vs_ctl;
    } sel_class_t;

endpackage

// File: rtl/ctr_sel_decode.sv
module ctr_sel_decode
    import ctr_gate_pkg::*;
(
    input  sel_e       sel_i,
    output sel_class_t cls_o
);

    always_comb begin
        cls_o = '0;
        case (sel_i)
            SEL_M_CTL:  cls_o.m_ctl    = 1'b1;
            SEL_S_CTL:  cls_o.s_ctl    = 1'b1;
            SEL_DEPTH:  cls_o.s_depth  = 1'b1;
            SEL_STATUS: cls_o.s_status = 1'b1;
            SEL_VS_CTL: cls_o.vs_ctl   = 1'b1;
            default:    cls_o          = '0;
        endcase
    end

endmodule

// File: rtl/ctr_route_gate.sv
module ctr_route_gate
    import ctr_gate_pkg::*;
(
    input  priv_e      priv_i,
    input  logic       virt_i,
    input  sel_class_t cls_i,
    input  logic       has_m_ext_i,
    input  logic       has_s_ext_i,
    output route_e     route_o
);

    logic at_m;
    logic at_s_host;
    logic at_s_guest;
    logic sup_path;
    logic guest_path;
    logic any_sup_reg;

    always_comb begin
        at_m        = (priv_i == PRIV_M);
        at_s_host   = (priv_i == PRIV_S) && !virt_i;
        at_s_guest  = (priv_i == PRIV_S) && virt_i;
        sup_path    = (at_m && has_m_ext_i) || (at_s_host && has_s_ext_i);
        guest_path  = at_s_guest && has_s_ext_i;
        any_sup_reg = cls_i.s_ctl || cls_i.s_depth || cls_i.s_status || cls_i.vs_ctl;

        route_o = ROUTE_ILL;
        if (cls_i.m_ctl) begin
            route_o = (at_m && has_m_ext_i) ? ROUTE_STATEEN : ROUTE_ILL;
        end else if (cls_i.vs_ctl && guest_path) begin
            route_o = ROUTE_STATEEN;
        end else if (any_sup_reg) begin
            if (sup_path) begin
                route_o = ROUTE_STATEEN;
            end else if (guest_path) begin
                route_o = cls_i.s_status ? ROUTE_STATEEN : ROUTE_VIRT;
            end
        end
    end

endmodule

// File: rtl/ctr_stateen_gate.sv
module ctr_stateen_gate
    import ctr_gate_pkg::*;
(
    input  priv_e    priv_i,
    input  logic     virt_i,
    input  logic     m_se_ctr_i,
    input  logic     h_se_ctr_i,
    output verdict_e se_o
);

    always_comb begin
        if (priv_i == PRIV_M) begin
            se_o = VERD_OK;
        end else if (!m_se_ctr_i) begin
            se_o = VERD_ILL;
        end else if (virt_i && !h_se_ctr_i) begin
            se_o = VERD_VIRT;
        end else begin
            se_o = VERD_OK;
        end
    end

endmodule

// File: rtl/ctr_csr_gate.sv
module ctr_csr_gate
    import ctr_gate_pkg::*;
(
    input  logic [1:0] priv_i,
    input  logic       virt_i,
    input  logic [2:0] sel_i,
    input  logic       has_m_ext_i,
    input  logic       has_s_ext_i,
    input  logic       m_se_ctr_i,
    input  logic       h_se_ctr_i,
    output logic [1:0] verdict_o
);

    priv_e      priv;
    sel_e       sel;
    sel_class_t cls;
    route_e     route;
    verdict_e   se_verdict;
    verdict_e   verdict_d;

    assign priv = priv_e'(priv_i);
    assign sel  = sel_e'(sel_i);

    ctr_sel_decode u_decode (
        .sel_i (sel),
        .cls_o (cls)
    );

    ctr_route_gate u_route (
        .priv_i      (priv),
        .virt_i      (virt_i),
        .cls_i       (cls),
        .has_m_ext_i (has_m_ext_i),
        .has_s_ext_i (has_s_ext_i),
        .route_o     (route)
    );

    ctr_stateen_gate u_stateen (
        .priv_i     (priv),
        .virt_i     (virt_i),
        .m_se_ctr_i (m_se_ctr_i),
        .h_se_ctr_i (h_se_ctr_i),
        .se_o       (se_verdict)
    );

    always_comb begin
        case (route)
            ROUTE_STATEEN: verdict_d = se_verdict;
            ROUTE_VIRT:    verdict_d = VERD_VIRT;
            default:       verdict_d = VERD_ILL;
        endcase
    end

    assign verdict_o = verdict_d;

endmodule

// File: rtl/ctr_csr_gate_chk.sv
module ctr_csr_gate_chk (
    input logic [1:0] priv_i,
    input logic       virt_i,
    input logic [2:0] sel_i,
    input logic       has_m_ext_i,
    input logic       has_s_ext_i,
    input logic       m_se_ctr_i,
    input logic       h_se_ctr_i,
    input logic [1:0] verdict_o
);

    always_comb begin
        if (!$isunknown({priv_i, virt_i, sel_i, has_m_ext_i, has_s_ext_i,
                         m_se_ctr_i, h_se_ctr_i, verdict_o})) begin
            // R1
            no_rsv_code_chk: assert (verdict_o != 2'b11);
            // R9
            user_blocked_chk: assert (priv_i != 2'b00 || verdict_o == 2'b01);
            // R2
            mctl_below_m_chk: assert (sel_i != 3'd0 || priv_i == 2'b11 || verdict_o == 2'b01);
            // R6
            unused_sel_chk: assert (sel_i < 3'd5 || verdict_o == 2'b01);
            // R8
            vfault_needs_guest_chk: assert (verdict_o != 2'b10 || (priv_i == 2'b01 && virt_i));
            // R7
            allow_needs_mse_chk: assert (verdict_o != 2'b00 || priv_i == 2'b11 || m_se_ctr_i);
        end
    end

endmodule

bind ctr_csr_gate ctr_csr_gate_chk u_chk (
    .priv_i      (priv_i),
    .virt_i      (virt_i),
    .sel_i       (sel_i),
    .has_m_ext_i (has_m_ext_i),
    .has_s_ext_i (has_s_ext_i),
    .m_se_ctr_i  (m_se_ctr_i),
    .h_se_ctr_i  (h_se_ctr_i),
    .verdict_o   (verdict_o)
);

// File: tb/tb_ctr_csr_gate.sv
module tb_ctr_csr_gate;

    localparam logic [1:0] OK = 2'b00, ILL = 2'b01, VF = 2'b10;
    localparam logic [1:0] PU = 2'b00, PS = 2'b01, PR = 2'b10, PM = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] priv_i = 2'b00;
    logic       virt_i = 1'b0;
    logic [2:0] sel_i = 3'd0;
    logic       has_m_ext_i = 1'b0;
    logic       has_s_ext_i = 1'b0;
    logic       m_se_ctr_i = 1'b0;
    logic       h_se_ctr_i = 1'b0;
    logic [1:0] verdict_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ctr_csr_gate dut (
        .priv_i      (priv_i),
        .virt_i      (virt_i),
        .sel_i       (sel_i),
        .has_m_ext_i (has_m_ext_i),
        .has_s_ext_i (has_s_ext_i),
        .m_se_ctr_i  (m_se_ctr_i),
        .h_se_ctr_i  (h_se_ctr_i),
        .verdict_o   (verdict_o)
    );

    function automatic logic [1:0] ref_se(logic [1:0] p, logic v, logic ms, logic hs);
        if (p == PM) return OK;
        if (!ms) return ILL;
        if (v && !hs) return VF;
        return OK;
    endfunction

    function automatic logic [1:0] ref_verdict(logic [1:0] p, logic v, logic [2:0] s,
                                               logic hm, logic hx, logic ms, logic hs);
        logic m_ok, host_ok, guest_ok;
        m_ok     = (p == PM) && hm;
        host_ok  = (p == PS) && !v && hx;
        guest_ok = (p == PS) && v && hx;
        if (s == 3'd0) return m_ok ? ref_se(p, v, ms, hs) : ILL;
        if (s == 3'd4 && guest_ok) return ref_se(p, v, ms, hs);
        if (s >= 3'd1 && s <= 3'd4) begin
            if (m_ok || host_ok) return ref_se(p, v, ms, hs);
            if (guest_ok) return (s == 3'd3) ? ref_se(p, v, ms, hs) : VF;
        end
        return ILL;
    endfunction

    function automatic string tag_of(logic [1:0] p, logic v, logic [2:0] s);
        if (p == PU) return "R9";
        if (p == PR || s >= 3'd5) return "R6";
        if (s == 3'd0) return "R2";
        if (s == 3'd4) return "R5";
        if (p == PS && v) return "R4";
        return "R3";
    endfunction

    task automatic drive(logic [1:0] p, logic v, logic [2:0] s,
                         logic hm, logic hx, logic ms, logic hs);
        @(posedge clk);
        priv_i = p; virt_i = v; sel_i = s;
        has_m_ext_i = hm; has_s_ext_i = hx; m_se_ctr_i = ms; h_se_ctr_i = hs;
        @(negedge clk);
    endtask

    task automatic check(string req, logic [1:0] exp);
        checks++;
        if (verdict_o !== exp) begin
            fails++;
            $display("FAIL %s priv=%b virt=%b sel=%0d hm=%b hs=%b mse=%b hse=%b actual=%b expected=%b",
                     req, priv_i, virt_i, sel_i, has_m_ext_i, has_s_ext_i,
                     m_se_ctr_i, h_se_ctr_i, verdict_o, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R9", ILL);
    endtask

    task automatic t_mctl();
        drive(PM, 0, 3'd0, 1, 1, 0, 0); check("R2", OK);
        drive(PM, 0, 3'd0, 0, 1, 1, 1); check("R2", ILL);
        drive(PS, 0, 3'd0, 1, 1, 1, 1); check("R2", ILL);
    endtask

    task automatic t_sup_host();
        drive(PM, 0, 3'd1, 1, 0, 0, 0); check("R3", OK);
        drive(PS, 0, 3'd2, 0, 1, 1, 0); check("R3", OK);
        drive(PS, 0, 3'd3, 1, 0, 1, 1); check("R3", ILL);
    endtask

    task automatic t_guest();
        drive(PS, 1, 3'd3, 0, 1, 1, 1); check("R4", OK);
        drive(PS, 1, 3'd1, 1, 1, 1, 1); check("R4", VF);
        drive(PS, 1, 3'd2, 1, 1, 0, 0); check("R4", VF);
    endtask

    task automatic t_vsctl();
        drive(PS, 1, 3'd4, 0, 1, 1, 1); check("R5", OK);
        drive(PM, 0, 3'd4, 1, 0, 0, 0); check("R5", OK);
        drive(PS, 0, 3'd4, 0, 1, 0, 1); check("R5", ILL);
    endtask

    task automatic t_other();
        drive(PM, 0, 3'd6, 1, 1, 1, 1); check("R6", ILL);
        drive(PR, 0, 3'd1, 1, 1, 1, 1); check("R6", ILL);
        drive(PS, 1, 3'd3, 1, 0, 1, 1); check("R6", ILL);
    endtask

    task automatic t_stateen();
        drive(PM, 1, 3'd2, 1, 1, 0, 0); check("R7", OK);
        drive(PS, 0, 3'd1, 0, 1, 0, 1); check("R7", ILL);
        drive(PS, 1, 3'd3, 0, 1, 1, 0); check("R8", VF);
        drive(PS, 1, 3'd4, 0, 1, 0, 0); check("R8", ILL);
    endtask

    task automatic t_user();
        drive(PU, 1, 3'd3, 1, 1, 1, 1); check("R9", ILL);
        drive(PU, 0, 3'd1, 1, 1, 1, 1); check("R9", ILL);
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 1024; i++) begin
            logic [9:0] b;
            b = i[9:0];
            drive(b[9:8], b[7], b[6:4], b[3], b[2], b[1], b[0]);
            if (verdict_o === 2'b11) check("R1", ILL);
            check(tag_of(b[9:8], b[7], b[6:4]),
                  ref_verdict(b[9:8], b[7], b[6:4], b[3], b[2], b[1], b[0]));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mctl();
        t_sup_host();
        t_guest();
        t_vsctl();
        t_other();
        t_stateen();
        t_user();
        t_sweep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule